// File: doc/BRIEF.md
# Linked Command List Executor

This block walks a chain of command descriptors held in memory and carries each one out. For every descriptor it first marks the descriptor as in progress. It then fetches the command word and dispatches on the command type. Afterwards it stores a completion status and follows a 32-bit forward pointer to the next descriptor. Three flag bits in the command word decide whether the walk stops at the current descriptor, whether the unit parks in a suspended state, and whether a completion event and interrupt pulse are raised.

Most command types are executed locally. Configure copies a variable number of bytes into an internal 14-byte settings store and then forces fixed values into a few of them. Link test writes the current link word back into the descriptor. Address setup, multicast list and transmit are handed to external units through a valid/done handshake that carries the kind and the descriptor base. Memory is reached through a 16-bit word request/acknowledge port with byte addresses. Within each 16-bit word the lower-addressed byte sits in bits 15:8. A 32-bit value is stored as its low half at the lower address and its high half two bytes above.

Top module: `cle_exec`

## Requirements
- R1: `cu_state` reads 0 (idle), 1 (suspended) or 2 (active). A `start` pulse while idle or suspended loads `start_ptr` as the current descriptor, and the unit reads active from the next cycle. A `start` pulse while active has no effect: no descriptor at the new pointer is touched.
- R2: Before the command word is fetched, 0x4000 is written at the descriptor base. After a successful command, 0xA000 is written there.
- R3: The command word sits at byte offset 2, and its bits 2:0 select the kind: 0 no-op, 1 address setup, 2 configure, 3 multicast list, 4 transmit, 5 link test, 6 dump, 7 diagnose. Kinds 1, 3 and 4 raise `act_valid` with `act_kind` and `act_ptr` (the descriptor base), and the unit waits for `act_done` before completing.
- R4: Dump (6) and diagnose (7) complete with status 0x9000 (complete and aborted, not OK), and the walk goes on as for any other command.
- R5: The next pointer is read from offset 4 (low half) and offset 6 (high half). A value of zero or 0xFFFFFFFF ends the walk, and the unit goes idle.
- R6: Command bit 15 ends the walk after the current descriptor even when its pointer is non-zero, and the unit goes idle.
- R7: Command bit 14 leaves the unit suspended after the current descriptor. No further descriptor is executed.
- R8: On completing a descriptor, `evt_done` takes the value of its command bit 13. When that bit is set, `irq` pulses high for one cycle.
- R9: Configure takes its byte count from the low nibble of the byte at offset 8 (bits 11:8 of the word at offset 8) and clamps it to 4..14. It copies that many bytes, starting at offset 8, to store indices 0 upward. Indices at or beyond the count keep their previous values.
- R10: After each configure copy, the store is corrected: byte 2 becomes (b & 0x82) | 0x40, byte 7 has bit 3 cleared, byte 10 is raised to at least 5, byte 12 keeps only bit 6, and byte 13 has bits 5:0 set.
- R11: Link test writes `link_state[15:0]` at offset 8 and `link_state[31:16]` at offset 10.
- R12: `cfg_byte` shows store byte `cfg_idx` in the same cycle. Indices 14 and 15 read 0, and after reset all bytes read 0.
- R13: A memory request keeps its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin walking at `start_ptr` |
| start_ptr | input | 32 | First descriptor byte address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| act_valid | output | 1 | External action requested |
| act_kind | output | 3 | Command kind of the action |
| act_ptr | output | 32 | Descriptor base for the action |
| act_done | input | 1 | External action finished |
| link_state | input | 32 | Value stored by link test |
| cfg_idx | input | 4 | Settings store read index |
| cfg_byte | output | 8 | Settings store byte at `cfg_idx` |
| cu_state | output | 2 | 0 idle, 1 suspended, 2 active |
| evt_done | output | 1 | Interrupt flag of the last completed descriptor |
| irq | output | 1 | One-cycle pulse on completion with interrupt flag |

## Verification
Each memory write lands on the clock edge that acknowledges it. `cu_state`, `evt_done` and `irq` all change on the edge that acknowledges the high half of the next pointer. `cfg_byte` follows `cfg_idx` combinationally, with the store updated one edge after the last configure word and corrected on the next. The bench waits at falling edges until `cu_state` leaves active, lets one more cycle pass so that an `irq` pulse from the final edge has been counted, and only then compares memory words, counts and state. Store bytes are read one time step after the index is driven.

// File: rtl/cle_pkg.sv
package cle_pkg;

    typedef enum logic [1:0] {
        CU_IDLE   = 2'd0,
        CU_SUSP   = 2'd1,
        CU_ACTIVE = 2'd2
    } cu_state_e;

    typedef enum logic [2:0] {
        K_NOP   = 3'd0,
        K_ADDR  = 3'd1,
        K_CFG   = 3'd2,
        K_MCAST = 3'd3,
        K_TX    = 3'd4,
        K_LINK  = 3'd5,
        K_DUMP  = 3'd6,
        K_DIAG  = 3'd7
    } cmd_kind_e;

    typedef struct packed {
        logic      last;
        logic      park;
        logic      notify;
        cmd_kind_e kind;
    } cmd_flags_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MARK,
        S_FETCH,
        S_EXEC,
        S_CFG,
        S_FIX,
        S_LT_LO,
        S_LT_HI,
        S_ACT,
        S_DONE,
        S_NX_LO,
        S_NX_HI
    } exec_state_e;

    localparam logic [15:0] STAT_BUSY  = 16'h4000;
    localparam logic [15:0] STAT_OK    = 16'hA000;
    localparam logic [15:0] STAT_ABORT = 16'h9000;
    localparam logic [31:0] PTR_NULL   = 32'hFFFF_FFFF;

    function automatic int clamp_count(input logic [3:0] nib, input int lo, input int hi);
        int v;
        v = int'(nib);
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return v;
    endfunction

    function automatic logic [7:0] fix_byte(input int idx, input logic [7:0] v);
        case (idx)
            2:       return (v & 8'h82) | 8'h40;
            7:       return v & 8'hF7;
            10:      return (v < 8'd5) ? 8'd5 : v;
            12:      return v & 8'h40;
            13:      return v | 8'h3F;
            default: return v;
        endcase
    endfunction

    function automatic logic needs_unit(input cmd_kind_e k);
        return (k == K_ADDR) || (k == K_MCAST) || (k == K_TX);
    endfunction

endpackage

// File: rtl/cle_cmd_decode.sv
module cle_cmd_decode
    import cle_pkg::*;
(
    input  logic [15:0] cmd_word,
    output cmd_flags_t  flags,
    output logic        is_ext,
    output logic        is_cfg,
    output logic        is_link,
    output logic [15:0] done_status
);

    always_comb begin
        flags.last   = cmd_word[15];
        flags.park   = cmd_word[14];
        flags.notify = cmd_word[13];
        flags.kind   = cmd_kind_e'(cmd_word[2:0]);
        is_ext       = needs_unit(flags.kind);
        is_cfg       = (flags.kind == K_CFG);
        is_link      = (flags.kind == K_LINK);
        done_status  = ((flags.kind == K_DUMP) || (flags.kind == K_DIAG)) ? STAT_ABORT : STAT_OK;
    end

endmodule

// File: rtl/cle_cfg_store.sv
module cle_cfg_store
    import cle_pkg::*;
#(
    parameter int N_BYTES = 14,
    parameter int IW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_hi,
    input  logic [7:0]    wr_lo,
    input  logic          wr_lo_en,
    input  logic          fix,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data
);

    logic [N_BYTES*8-1:0] flat;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                b_q <= '0;
            end else if (wr_en && int'(wr_idx) == g) begin
                b_q <= wr_hi;
            end else if (wr_en && wr_lo_en && int'(wr_idx) + 1 == g) begin
                b_q <= wr_lo;
            end else if (fix) begin
                b_q <= fix_byte(g, b_q);
            end
        end
        assign flat[g*8 +: 8] = b_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_BYTES; i++) begin
            if (int'(rd_idx) == i) rd_data = flat[i*8 +: 8];
        end
    end

    if (N_BYTES >= 14) begin : g_chk
        AST_FIX_APPLIED: assert property (@(posedge clk) disable iff (rst)
            fix |=> (flat[2*8 +: 8] & 8'h3D) == 8'h00 && flat[2*8+6] == 1'b1
                    && flat[7*8+3] == 1'b0 && flat[10*8 +: 8] >= 8'd5
                    && (flat[12*8 +: 8] & 8'hBF) == 8'h00 && flat[13*8 +: 6] == 6'h3F); // R10
    end

endmodule

// File: rtl/cle_exec.sv
module cle_exec
    import cle_pkg::*;
#(
    parameter int CFG_BYTES = 14,
    parameter int CFG_MIN   = 4,
    parameter int CFG_OFF   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] start_ptr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata,
    output logic        act_valid,
    output logic [2:0]  act_kind,
    output logic [31:0] act_ptr,
    input  logic        act_done,
    input  logic [31:0] link_state,
    input  logic [3:0]  cfg_idx,
    output logic [7:0]  cfg_byte,
    output logic [1:0]  cu_state,
    output logic        evt_done,
    output logic        irq
);

    localparam int IW = $clog2(CFG_BYTES);
    localparam int CW = $clog2(CFG_BYTES + 2) + 1;

    exec_state_e      state_q;
    cu_state_e        cu_q;
    logic [31:0]      desc_q;
    logic [15:0]      cmd_q;
    logic [15:0]      nx_lo_q;
    logic [CW-1:0]    cfg_w_q;
    logic [CW-1:0]    cfg_n_q;
    logic             evt_q;
    logic             irq_q;

    cmd_flags_t       flags;
    logic             is_ext, is_cfg, is_link;
    logic [15:0]      done_status;

    logic [CW-1:0]    base;
    logic [CW-1:0]    n_eff;
    logic             lo_en;
    logic             last_word;
    logic             cfg_wr;
    logic             cfg_fix;
    logic [31:0]      next_ptr;
    logic             next_end;

    cle_cmd_decode u_dec (
        .cmd_word    (cmd_q),
        .flags       (flags),
        .is_ext      (is_ext),
        .is_cfg      (is_cfg),
        .is_link     (is_link),
        .done_status (done_status)
    );

    // Configure copy bookkeeping: two bytes per memory word
    always_comb begin
        base      = CW'({cfg_w_q[CW-2:0], 1'b0});
        n_eff     = (cfg_w_q == '0) ? CW'(clamp_count(mem_rdata[11:8], CFG_MIN, CFG_BYTES)) : cfg_n_q;
        lo_en     = CW'(base + CW'(1)) < n_eff;
        last_word = CW'(base + CW'(2)) >= n_eff;
        cfg_wr    = (state_q == S_CFG) && mem_ack;
        cfg_fix   = (state_q == S_FIX);
        next_ptr  = {mem_rdata, nx_lo_q};
        next_end  = (next_ptr == 32'd0) || (next_ptr == PTR_NULL) || flags.last;
    end

    cle_cfg_store #(.N_BYTES(CFG_BYTES), .IW(IW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_idx   (base[IW-1:0]),
        .wr_hi    (mem_rdata[15:8]),
        .wr_lo    (mem_rdata[7:0]),
        .wr_lo_en (lo_en),
        .fix      (cfg_fix),
        .rd_idx   (cfg_idx),
        .rd_data  (cfg_byte)
    );

    // Memory port drive
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_q;
        mem_wdata = '0;
        case (state_q)
            S_MARK:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = STAT_BUSY; end
            S_FETCH: begin mem_req = 1'b1; mem_addr = desc_q + 32'd2; end
            S_CFG:   begin mem_req = 1'b1; mem_addr = desc_q + 32'(CFG_OFF) + 32'(base); end
            S_LT_LO: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_q + 32'd8;
                           mem_wdata = link_state[15:0]; end
            S_LT_HI: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_q + 32'd10;
                           mem_wdata = link_state[31:16]; end
            S_DONE:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = done_status; end
            S_NX_LO: begin mem_req = 1'b1; mem_addr = desc_q + 32'd4; end
            S_NX_HI: begin mem_req = 1'b1; mem_addr = desc_q + 32'd6; end
            default: ;
        endcase
    end

    // Walk sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cu_q    <= CU_IDLE;
            desc_q  <= '0;
            cmd_q   <= '0;
            nx_lo_q <= '0;
            cfg_w_q <= '0;
            cfg_n_q <= '0;
            evt_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        desc_q  <= start_ptr;
                        cu_q    <= CU_ACTIVE;
                        state_q <= S_MARK;
                    end
                end
                S_MARK:  if (mem_ack) state_q <= S_FETCH;
                S_FETCH: begin
                    if (mem_ack) begin
                        cmd_q   <= mem_rdata;
                        state_q <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    cfg_w_q <= '0;
                    if (is_cfg)       state_q <= S_CFG;
                    else if (is_link) state_q <= S_LT_LO;
                    else if (is_ext)  state_q <= S_ACT;
                    else              state_q <= S_DONE;
                end
                S_CFG: begin
                    if (mem_ack) begin
                        cfg_n_q <= n_eff;
                        cfg_w_q <= cfg_w_q + CW'(1);
                        if (last_word) state_q <= S_FIX;
                    end
                end
                S_FIX:   state_q <= S_DONE;
                S_LT_LO: if (mem_ack) state_q <= S_LT_HI;
                S_LT_HI: if (mem_ack) state_q <= S_DONE;
                S_ACT:   if (act_done) state_q <= S_DONE;
                S_DONE:  if (mem_ack) state_q <= S_NX_LO;
                S_NX_LO: begin
                    if (mem_ack) begin
                        nx_lo_q <= mem_rdata;
                        state_q <= S_NX_HI;
                    end
                end
                S_NX_HI: begin
                    if (mem_ack) begin
                        evt_q <= flags.notify;
                        irq_q <= flags.notify;
                        if (flags.park) begin
                            cu_q    <= CU_SUSP;
                            state_q <= S_IDLE;
                        end else if (next_end) begin
                            cu_q    <= CU_IDLE;
                            state_q <= S_IDLE;
                        end else begin
                            desc_q  <= next_ptr;
                            state_q <= S_MARK;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign act_valid = (state_q == S_ACT);
    assign act_kind  = flags.kind;
    assign act_ptr   = desc_q;
    assign cu_state  = cu_q;
    assign evt_done  = evt_q;
    assign irq       = irq_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13

    AST_ACT_HELD: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !act_done) |=> (act_valid && $stable(act_kind) && $stable(act_ptr))); // R3

    AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cu_q != CU_ACTIVE) |-> (state_q == S_IDLE)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && state_q != S_IDLE && state_q != S_NX_HI) |=> $stable(desc_q)); // R1

    AST_IRQ_WITH_EVT: assert property (@(posedge clk) disable iff (rst)
        irq |-> evt_done); // R8

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R8

endmodule

// File: tb/cle_exec_test.sv
module cle_exec_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata;
    logic        act_valid;
    logic [2:0]  act_kind;
    logic [31:0] act_ptr;
    logic        act_done = 1'b0;
    logic        act_stall = 1'b0;
    logic [31:0] link_state = 32'hDEAD_BEEF;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_byte;
    logic [1:0]  cu_state;
    logic        evt_done, irq;

    logic [15:0] mem [0:255];
    int          n_vec = 0;
    int          n_bad = 0;
    int          irq_cnt = 0;
    int          act_cnt = 0;
    logic [2:0]  last_kind = '0;
    logic [31:0] last_ptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cle_exec uut (
        .clk(clk), .rst(rst), .start(start), .start_ptr(start_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .act_valid(act_valid), .act_kind(act_kind), .act_ptr(act_ptr), .act_done(act_done),
        .link_state(link_state), .cfg_idx(cfg_idx), .cfg_byte(cfg_byte),
        .cu_state(cu_state), .evt_done(evt_done), .irq(irq)
    );

    // memory and external unit responders, one wait cycle each
    assign mem_rdata = mem[mem_addr[8:1]];
    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && mem_we && mem_ack) mem[mem_addr[8:1]] <= mem_wdata;
        act_done <= act_valid && !act_done && !act_stall;
        if (act_valid && act_done) begin
            act_cnt   <= act_cnt + 1;
            last_kind <= act_kind;
            last_ptr  <= act_ptr;
        end
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    typedef struct packed {
        logic [15:0] cmd;
        logic        lz;
        logic [15:0] st1;
        logic [15:0] st2;
        logic [1:0]  cu;
        logic        evt;
        logic [1:0]  irqs;
        logic [1:0]  acts;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 1'b0, 16'hA000, 16'hA000, 2'd0, 1'b0, 2'd0, 2'd0}, // R2 R5 chained no-op
        '{16'h8000, 1'b0, 16'hA000, 16'h0000, 2'd0, 1'b0, 2'd0, 2'd0}, // R6 end flag
        '{16'h4000, 1'b0, 16'hA000, 16'h0000, 2'd1, 1'b0, 2'd0, 2'd0}, // R7 park
        '{16'h2000, 1'b0, 16'hA000, 16'hA000, 2'd0, 1'b0, 2'd1, 2'd0}, // R8 event cleared by next
        '{16'hA000, 1'b0, 16'hA000, 16'h0000, 2'd0, 1'b1, 2'd1, 2'd0}, // R8 event kept
        '{16'h0004, 1'b0, 16'hA000, 16'hA000, 2'd0, 1'b0, 2'd0, 2'd1}, // R3 transmit
        '{16'h8006, 1'b0, 16'h9000, 16'h0000, 2'd0, 1'b0, 2'd0, 2'd0}, // R4 dump
        '{16'h0007, 1'b0, 16'h9000, 16'hA000, 2'd0, 1'b0, 2'd0, 2'd0}, // R4 diagnose continues
        '{16'h0000, 1'b1, 16'hA000, 16'h0000, 2'd0, 1'b0, 2'd0, 2'd0}, // R5 zero pointer
        '{16'h6003, 1'b0, 16'hA000, 16'h0000, 2'd1, 1'b1, 2'd1, 2'd1}, // R3 R7 R8 multicast
        '{16'h8001, 1'b0, 16'hA000, 16'h0000, 2'd0, 1'b0, 2'd0, 2'd1}  // R3 address setup
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [15:0] v);
        mem[addr[8:1]] = v;
    endtask

    task automatic run(input logic [31:0] p);
        @(negedge clk);
        irq_cnt = 0;
        act_cnt = 0;
        start = 1'b1;
        start_ptr = p;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && cu_state == 2'd2; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_cfg(input int idx, input logic [7:0] exp, input string tag);
        cfg_idx = 4'(idx);
        #1;
        check(cfg_byte == exp, tag, {24'd0, cfg_byte}, {24'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check(cu_state == 2'd0, "R1 reset state", {30'd0, cu_state}, 32'd0);
        check(evt_done == 1'b0 && irq == 1'b0, "R8 reset outputs", {30'd0, evt_done, irq}, 32'd0);
        begin
            logic allz;
            allz = 1'b1;
            for (int i = 0; i < 16; i++) begin
                cfg_idx = 4'(i);
                #1;
                if (cfg_byte != 8'd0) allz = 1'b0;
            end
            check(allz, "R12 store zero after reset", {31'd0, allz}, 32'd1);
        end

        // table-driven single/double descriptor runs
        for (int v = 0; v < NV; v++) begin
            wr(16'h40, 16'h0000);
            wr(16'h42, VECS[v].cmd);
            wr(16'h44, VECS[v].lz ? 16'h0000 : 16'h0080);
            wr(16'h46, 16'h0000);
            wr(16'h80, 16'h0000);
            wr(16'h82, 16'h8000);
            wr(16'h84, 16'h0000);
            wr(16'h86, 16'h0000);
            run(32'h40);
            check(mem[8'h20] == VECS[v].st1, "R2 first status", {16'd0, mem[8'h20]}, {16'd0, VECS[v].st1});
            check(mem[8'h40] == VECS[v].st2, "R5 second status", {16'd0, mem[8'h40]}, {16'd0, VECS[v].st2});
            check(cu_state == VECS[v].cu, "R7 unit state", {30'd0, cu_state}, {30'd0, VECS[v].cu});
            check(evt_done == VECS[v].evt, "R8 event", {31'd0, evt_done}, {31'd0, VECS[v].evt});
            check(irq_cnt == int'(VECS[v].irqs), "R8 irq pulses", irq_cnt, {30'd0, VECS[v].irqs});
            check(act_cnt == int'(VECS[v].acts), "R3 actions", act_cnt, {30'd0, VECS[v].acts});
            if (VECS[v].acts != 2'd0) begin
                check(last_kind == VECS[v].cmd[2:0] && last_ptr == 32'h40, "R3 action kind/ptr",
                      {last_ptr[27:0], 1'b0, last_kind}, {28'h40, 1'b0, VECS[v].cmd[2:0]});
            end
        end

        // configure: count 2 clamps to 4
        wr(16'h42, 16'h8002);
        wr(16'h48, 16'h1234);
        wr(16'h4A, 16'hFF5A);
        wr(16'h4C, 16'hAABB);
        run(32'h40);
        chk_cfg(0, 8'h12, "R9 count byte copied");
        chk_cfg(1, 8'h34, "R9 byte 1");
        chk_cfg(2, 8'hC2, "R10 byte 2 fixed");
        chk_cfg(3, 8'h5A, "R9 byte 3");
        chk_cfg(4, 8'h00, "R9 clamp to 4 leaves byte 4");
        chk_cfg(10, 8'h05, "R10 byte 10 minimum");
        chk_cfg(13, 8'h3F, "R10 byte 13 ones");

        // configure: nibble 15 clamps to 14
        wr(16'h48, 16'h0F11); wr(16'h4A, 16'h3D33); wr(16'h4C, 16'h4455);
        wr(16'h4E, 16'h66FF); wr(16'h50, 16'h8899); wr(16'h52, 16'h03BB);
        wr(16'h54, 16'hFF80); wr(16'h56, 16'h7777);
        run(32'h40);
        chk_cfg(2, 8'h40, "R10 byte 2 mask");
        chk_cfg(7, 8'hF7, "R10 byte 7");
        chk_cfg(10, 8'h05, "R10 byte 10 raised");
        chk_cfg(11, 8'hBB, "R9 byte 11");
        chk_cfg(12, 8'h40, "R10 byte 12");
        chk_cfg(13, 8'hBF, "R10 byte 13");
        chk_cfg(14, 8'h00, "R12 out of range index");

        // configure: odd count 5 keeps byte 5
        wr(16'h48, 16'h0501); wr(16'h4A, 16'h0203); wr(16'h4C, 16'h04EE);
        run(32'h40);
        chk_cfg(4, 8'h04, "R9 byte 4 copied");
        chk_cfg(5, 8'h55, "R9 byte 5 untouched");
        chk_cfg(9, 8'h99, "R9 byte 9 untouched");

        // link test
        wr(16'h42, 16'h8005);
        wr(16'h48, 16'h0000); wr(16'h4A, 16'h0000);
        run(32'h40);
        check(mem[8'h24] == 16'hBEEF, "R11 link low", {16'd0, mem[8'h24]}, 32'hBEEF);
        check(mem[8'h25] == 16'hDEAD, "R11 link high", {16'd0, mem[8'h25]}, 32'hDEAD);

        // start while active is ignored
        wr(16'h40, 16'h0000);
        wr(16'h42, 16'h8004);
        wr(16'h80, 16'h0000);
        act_stall = 1'b1;
        @(negedge clk);
        start = 1'b1;
        start_ptr = 32'h40;
        @(negedge clk);
        start = 1'b0;
        check(cu_state == 2'd2, "R1 active after start", {30'd0, cu_state}, 32'd2);
        for (int i = 0; i < 100 && !act_valid; i++) @(negedge clk);
        check(mem[8'h20] == 16'h4000, "R2 busy mark", {16'd0, mem[8'h20]}, 32'h4000);
        start = 1'b1;
        start_ptr = 32'h80;
        @(negedge clk);
        start = 1'b0;
        act_stall = 1'b0;
        for (int i = 0; i < 200 && cu_state == 2'd2; i++) @(negedge clk);
        @(negedge clk);
        check(mem[8'h40] == 16'h0000, "R1 start ignored while active", {16'd0, mem[8'h40]}, 32'd0);
        check(last_ptr == 32'h40, "R1 walk kept its pointer", last_ptr, 32'h40);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule